// File: doc/BRIEF.md
# Interleaved DRAM Row/Column Mapper

This block takes a CPU byte offset measured from the start of a bank window and turns it into the DRAM coordinates that a memory controller needs. The outputs are the index of the bank to use, an 11-bit row address, an 11-bit column address, and a linear physical address rebuilt from that row and column. The window can hold one bank, two interleaved banks or four interleaved banks. Each layout can use page ordering, where consecutive offsets walk the column, or non-page ordering, where consecutive offsets walk the row. Four device sizes are supported. The row and column bits are collected from scattered high offset bits, and which bits are used depends on the size and on the interleave mode.

A request is accepted when its strobe is high. The result is registered and appears one cycle later. An invalid flag marks requests that cannot be mapped. Adding the physical base address of the bank is left to the surrounding logic.

Top module: `dram_rc_mapper`

## Requirements
- R1: After reset, all outputs are zero. A request with `req_valid` high at a rising edge produces its result on the outputs from that edge on, and `rsp_valid` is high for that one cycle. When no request is presented, `rsp_valid` is low and every other output holds its value.
- R2: `req_size` selects the device size: 0 is 128 KiB with 8-bit row and column, 1 is 512 KiB with 9 bits, 2 is 2 MiB with 10 bits, and 3 is 8 MiB with 11 bits. The geometry width is g = 8 + size. Codes 4 to 7 are invalid.
- R3: `rsp_row` and `rsp_col` are the gathered row and column, each masked to g bits. `rsp_phys` = (row << (g+1)) | (col << 1) | offset[0].
- R4: With no interleave (`req_ilv` = 0) in page mode (`req_page` = 1), the column is offset[11:1]. The row is built as follows: row[7:0] is offset[16:9], but its low `size` bits are replaced, in order from bit 0, by offset bits 17, 19 and 21. Row[10:8] is {offset[22], offset[20], offset[18]}.
- R5: With no interleave in non-page mode, the row is offset[11:1]. The column is built the way R4 builds the row.
- R6: With two-way interleave (`req_ilv` = 1) in page mode, the column is offset[11:1]. The row is built as in R4, but size+1 low bits are replaced, taken from the list 17, 19, 21, 23. The select bit is offset[9+size].
- R7: With two-way interleave in non-page mode, the row is {offset[11:2], offset[13]}. Column bits 10 to 8 are {offset[22], offset[20], offset[18]} and column bits 7 to 5 are offset[16:14]. Column bits 4 to 0, most significant bit first, are {o17,o12,o11,o10,o9} for size 0, {o19,o12,o11,o10,o17} for size 1, {o21,o12,o11,o19,o17} for size 2 and {o12,o23,o21,o19,o17} for size 3. The select bit is offset[1].
- R8: With four-way interleave (`req_ilv` = 2) in page mode, the row is built as in R4, but size+2 low bits are replaced, taken from the list 17, 19, 21, 23, 24. The column is offset[11:1] and the two select bits are offset[10+size:9+size]. Four-way interleave in non-page mode is invalid, and so is `req_ilv` = 3.
- R9: The request is invalid when the offset is 2^(17+2·size) times the number of interleaved banks or larger.
- R10: `rsp_bank` is `req_base` ORed with the select bits. The select bits are zero without interleave, and in two-way mode the select bit is bit 0. The request is invalid when `bank_present` bit `rsp_bank` is 0.
- R11: For an invalid request, `rsp_invalid` is 1, `rsp_phys` is all ones, and `rsp_row`, `rsp_col` and `rsp_bank` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ofs | input | 25 | Byte offset within the bank window |
| req_size | input | 3 | Device size code |
| req_ilv | input | 2 | Interleave mode: 0 none, 1 two-way, 2 four-way |
| req_page | input | 1 | 1 for page ordering, 0 for non-page ordering |
| req_base | input | 2 | Index of the base bank |
| bank_present | input | 4 | One bit per bank; 1 when the bank has nonzero physical size |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_invalid | output | 1 | The request could not be mapped |
| rsp_bank | output | 2 | Selected bank index |
| rsp_row | output | 11 | Row address |
| rsp_col | output | 11 | Column address |
| rsp_phys | output | 23 | Linear physical address within the bank |

## Verification
A wrong bit-gather choice shows up as a single misplaced bit in `rsp_row`, `rsp_col` or `rsp_phys`, and it does so in the cycle right after the request. Driving walking-one offsets through every combination of size, mode and ordering exposes each bit route on its own. A wrong select position shows up as the wrong `rsp_bank`, or as a spurious invalid flag when that bank is marked absent. Offsets just below and just above each window limit exercise the range check in the same cycle.

// File: rtl/dram_rc_mapper.sv
module dram_rc_mapper (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [24:0] req_ofs,
  input  logic [2:0]  req_size,
  input  logic [1:0]  req_ilv,
  input  logic        req_page,
  input  logic [1:0]  req_base,
  input  logic [3:0]  bank_present,
  output logic        rsp_valid,
  output logic        rsp_invalid,
  output logic [1:0]  rsp_bank,
  output logic [10:0] rsp_row,
  output logic [10:0] rsp_col,
  output logic [22:0] rsp_phys
);
  localparam int OW = 25;
  localparam int AW = 23;

  logic [1:0]    k;
  logic [1:0]    wlog;
  logic [4:0]    odd_v;
  logic [2:0]    hi3;
  logic [2:0]    n_pg;
  logic [7:0]    pg_lo, np_lo;
  logic [4:0]    tw_lo;
  logic [OW-1:0] sh;
  logic [10:0]   row, col, rmask;
  logic [1:0]    sel, bank;
  logic [4:0]    win_idx;
  logic          over, bad;
  logic [AW-1:0] phys;

  assign k     = req_size[1:0];
  assign wlog  = (req_ilv == 2'd1) ? 2'd1 : (req_ilv == 2'd2) ? 2'd2 : 2'd0;
  assign odd_v = {req_ofs[24], req_ofs[23], req_ofs[21], req_ofs[19], req_ofs[17]};
  assign hi3   = {req_ofs[22], req_ofs[20], req_ofs[18]};
  assign n_pg  = {1'b0, k} + {1'b0, wlog};
  assign sh    = req_ofs >> (5'd9 + {3'd0, k});
  assign rmask = 11'h7ff >> (2'd3 - k);
  assign win_idx = 5'd17 + {2'd0, k, 1'b0} + {3'd0, wlog};
  assign over  = (win_idx < 5'd25) && ((req_ofs >> win_idx) != '0);

  always_comb begin
    pg_lo = req_ofs[16:9];
    np_lo = req_ofs[16:9];
    for (int j = 0; j < 5; j++)
      if (j < int'(n_pg)) pg_lo[j] = odd_v[j];
    for (int j = 0; j < 3; j++)
      if (j < int'(k)) np_lo[j] = odd_v[j];
    case (k)
      2'd0:    tw_lo = {req_ofs[17], req_ofs[12], req_ofs[11], req_ofs[10], req_ofs[9]};
      2'd1:    tw_lo = {req_ofs[19], req_ofs[12], req_ofs[11], req_ofs[10], req_ofs[17]};
      2'd2:    tw_lo = {req_ofs[21], req_ofs[12], req_ofs[11], req_ofs[19], req_ofs[17]};
      default: tw_lo = {req_ofs[12], req_ofs[23], req_ofs[21], req_ofs[19], req_ofs[17]};
    endcase
  end

  always_comb begin
    if (req_page) begin
      row = {hi3, pg_lo};
      col = req_ofs[11:1];
      sel = (wlog == 2'd2) ? sh[1:0] : (wlog == 2'd1) ? {1'b0, sh[0]} : 2'd0;
    end else if (wlog == 2'd1) begin
      row = {req_ofs[11:2], req_ofs[13]};
      col = {hi3, req_ofs[16:14], tw_lo};
      sel = {1'b0, req_ofs[1]};
    end else begin
      row = req_ofs[11:1];
      col = {hi3, np_lo};
      sel = 2'd0;
    end
    row  = row & rmask;
    col  = col & rmask;
    bank = req_base | sel;
    phys = ({12'd0, row} << (5'd9 + {3'd0, k})) | ({12'd0, col} << 1) | {{(AW-1){1'b0}}, req_ofs[0]};
  end

  assign bad = req_size[2] || (req_ilv == 2'd3) || (req_ilv == 2'd2 && !req_page)
               || over || !bank_present[bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_invalid <= 1'b0;
      rsp_bank    <= '0;
      rsp_row     <= '0;
      rsp_col     <= '0;
      rsp_phys    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_invalid <= bad;
        rsp_bank    <= bad ? 2'd0 : bank;
        rsp_row     <= bad ? 11'd0 : row;
        rsp_col     <= bad ? 11'd0 : col;
        rsp_phys    <= bad ? '1 : phys;
      end
    end
  end
endmodule

module dram_rc_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [24:0] req_ofs,
  input logic [2:0]  req_size,
  input logic [1:0]  req_ilv,
  input logic        req_page,
  input logic [1:0]  req_base,
  input logic        rsp_valid,
  input logic        rsp_invalid,
  input logic [1:0]  rsp_bank,
  input logic [10:0] rsp_row,
  input logic [22:0] rsp_phys
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_phys) && $stable(rsp_invalid));
  p_badsize_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size[2] |=> rsp_invalid);
  p_small_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 3'd0 |=> rsp_invalid || rsp_phys < 23'h20000);
  p_quad_nopage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ilv == 2'd2 && !req_page |=> rsp_invalid);
  p_base_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ilv == 2'd0 |=> rsp_invalid || rsp_bank == $past(req_base));
  p_invalid_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_invalid |-> (&rsp_phys) && rsp_row == 11'd0 && rsp_bank == 2'd0);
endmodule

bind dram_rc_mapper dram_rc_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ofs(req_ofs),
  .req_size(req_size), .req_ilv(req_ilv), .req_page(req_page), .req_base(req_base),
  .rsp_valid(rsp_valid), .rsp_invalid(rsp_invalid), .rsp_bank(rsp_bank),
  .rsp_row(rsp_row), .rsp_phys(rsp_phys)
);

// File: tb/tb_dram_rc_mapper.sv
module tb_dram_rc_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [24:0] req_ofs = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_ilv = '0;
  logic        req_page = 1'b0;
  logic [1:0]  req_base = '0;
  logic [3:0]  bank_present = 4'hf;
  logic        rsp_valid, rsp_invalid;
  logic [1:0]  rsp_bank;
  logic [10:0] rsp_row, rsp_col;
  logic [22:0] rsp_phys;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_rc_mapper dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ofs(req_ofs),
    .req_size(req_size), .req_ilv(req_ilv), .req_page(req_page), .req_base(req_base),
    .bank_present(bank_present), .rsp_valid(rsp_valid), .rsp_invalid(rsp_invalid),
    .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_col(rsp_col), .rsp_phys(rsp_phys)
  );

  function automatic int bitof(logic [24:0] o, int p);
    return int'(o[p]);
  endfunction

  // Expected result computed from the requirements
  task automatic model(input logic [24:0] o, input int sz, input int ilv, input int pg,
                       input int base, input logic [3:0] pres,
                       output logic e_inv, output logic [1:0] e_bank, output logic [10:0] e_row,
                       output logic [10:0] e_col, output logic [22:0] e_phys, output string tag);
    int g, ways, r, c, s, nrep, b;
    int oddp[5] = '{17, 19, 21, 23, 24};
    int twmap[4][5] = '{'{9,10,11,12,17}, '{17,10,11,12,19}, '{17,19,11,12,21}, '{17,19,21,23,12}};
    longint win;
    logic inv;
    r = 0; c = 0; s = 0;
    ways = (ilv == 1) ? 2 : (ilv == 2) ? 4 : 1;
    g = 8 + (sz % 4);
    tag = (ilv >= 2) ? "R8" : (ilv == 1) ? (pg != 0 ? "R6" : "R7") : (pg != 0 ? "R4" : "R5");
    inv = 0;
    if (sz > 3) begin inv = 1; tag = "R2"; end
    if (ilv == 3 || (ilv == 2 && pg == 0)) inv = 1;
    if (!inv) begin
      win = 64'd1 << (17 + 2 * sz);
      win = win * ways;
      if (longint'(o) >= win) begin inv = 1; tag = "R9"; end
    end
    if (!inv) begin
      // byte-9 gather with odd-bit replacement
      nrep = (pg != 0) ? sz + (ways == 4 ? 2 : ways == 2 ? 1 : 0) : sz;
      b = 0;
      for (int j = 0; j < 8; j++) b += (j < nrep ? bitof(o, oddp[j < 5 ? j : 0]) : bitof(o, 9 + j)) << j;
      b += bitof(o, 18) << 8; b += bitof(o, 20) << 9; b += bitof(o, 22) << 10;
      if (pg != 0) begin
        r = b; c = int'(o[11:1]);
        if (ways == 2) s = bitof(o, 9 + sz);
        if (ways == 4) s = bitof(o, 9 + sz) + 2 * bitof(o, 10 + sz);
      end else if (ways == 2) begin
        r = (int'(o[11:2]) << 1) | bitof(o, 13);
        c = 0;
        for (int j = 0; j < 5; j++) c += bitof(o, twmap[sz][j]) << j;
        for (int j = 5; j < 8; j++) c += bitof(o, 9 + j) << j;
        c += bitof(o, 18) << 8; c += bitof(o, 20) << 9; c += bitof(o, 22) << 10;
        s = bitof(o, 1);
      end else begin
        r = int'(o[11:1]); c = b;
      end
      r = r % (1 << g); c = c % (1 << g);
      s = base | s;
      if (pres[s] == 1'b0) begin inv = 1; tag = "R10"; end
    end
    e_inv = inv;
    if (inv) begin
      e_bank = 0; e_row = 0; e_col = 0; e_phys = '1;
    end else begin
      e_bank = 2'(s); e_row = 11'(r); e_col = 11'(c);
      e_phys = 23'(r * (1 << (g + 1)) + c * 2 + bitof(o, 0));
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic run_one(input logic [24:0] o, input int sz, input int ilv, input int pg,
                         input int base, input logic [3:0] pres);
    logic e_inv; logic [1:0] e_bank; logic [10:0] e_row, e_col; logic [22:0] e_phys;
    string tag;
    model(o, sz, ilv, pg, base, pres, e_inv, e_bank, e_row, e_col, e_phys, tag);
    req_valid = 1'b1; req_ofs = o; req_size = 3'(sz); req_ilv = 2'(ilv);
    req_page = pg[0]; req_base = 2'(base); bank_present = pres;
    @(negedge clk);
    chk({tag, "/R1/R3/R11/R10"}, {rsp_valid, rsp_invalid, rsp_bank, rsp_row, rsp_col, rsp_phys},
        {1'b1, e_inv, e_bank, e_row, e_col, e_phys});
  endtask

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [24:0] lfsr;
    logic [63:0] snap;
    int szs[5] = '{0, 1, 2, 3, 5};
    lfsr = 25'h1a5c3e7;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {rsp_valid, rsp_invalid, rsp_bank, rsp_row, rsp_col, rsp_phys}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int si = 0; si < 5; si++)
      for (int ilv = 0; ilv < 4; ilv++)
        for (int pg = 0; pg < 2; pg++)
          for (int base = 0; base < 4; base++)
            for (int pi = 0; pi < 2; pi++) begin
              logic [3:0] pres;
              pres = (pi == 0) ? 4'hf : 4'hb;
              for (int b = 0; b < 25; b++) run_one(25'd1 << b, szs[si], ilv, pg, base, pres);
              for (int b = 17; b < 26; b++) run_one(25'((64'd1 << b) - 1), szs[si], ilv, pg, base, pres);
              for (int t = 0; t < 6; t++) begin
                lfsr = {lfsr[23:0], lfsr[24] ^ lfsr[21]};
                run_one(lfsr, szs[si], ilv, pg, base, pres);
              end
            end
    // R1 hold: no strobe, changed inputs, outputs must not move
    snap = {1'b1, rsp_invalid, rsp_bank, rsp_row, rsp_col, rsp_phys};
    req_valid = 1'b0; req_ofs = ~req_ofs; req_size = 3'd1; req_ilv = 2'd1; req_page = ~req_page;
    @(negedge clk);
    chk("R1 hold", {~rsp_valid, rsp_invalid, rsp_bank, rsp_row, rsp_col, rsp_phys}, snap);
    @(negedge clk);
    chk("R1 hold2", {~rsp_valid, rsp_invalid, rsp_bank, rsp_row, rsp_col, rsp_phys}, snap);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule